// File: doc/BRIEF.md
# Multi-Channel Chained DMA Controller

This block moves single data units between locations on a simple on-chip memory bus, on behalf of several independent channels. Each channel holds a source pointer, a destination pointer, a unit count and a control word. The control word sets the unit size (byte or halfword), whether each pointer advances or stays fixed, the interrupt mask, and which event starts a transfer. That event is a software pulse, one of the peripheral request lines (for example an A-D conversion done, a timer match or a serial data event), or the terminal count of another channel. With the last choice, a chain of transfers runs with no CPU help.

Each accepted request moves one unit in two bus cycles. The first is a read from the source pointer. The second is a write of the returned data to the destination pointer. When the count reaches its end, the channel disables itself, sets its sticky done flag and may raise an interrupt. A fixed-priority arbiter picks the lowest-numbered pending channel whenever the engine is idle. The memory returns read data one cycle after the read request.

Top module: `dma_ctrl`

## Requirements
- R1: After reset there is no bus request, every done flag is 0 and `irq` is 0.
- R2: A granted channel drives a read cycle at its source pointer (`mem_req`=1, `mem_we`=0). The next cycle is a write cycle at its destination pointer (`mem_req`=1, `mem_we`=1), with `mem_wdata` equal to `mem_rdata`.
- R3: After each unit, a pointer whose increment bit is set advances by 2 in halfword mode and by 1 in byte mode. A pointer without the increment bit stays fixed. `mem_half` reflects the channel's size bit in both cycles.
- R4: The count drops by one per unit. The unit taken while the count is 1 is the last one: it clears the channel enable, so later triggers start nothing. A loaded count of 0 wraps and gives 2^CW units.
- R5: In trigger mode 1, a pulse on `periph_req[idx]` marks the channel pending. Pulses on other lines have no effect, and an `idx` of NPER or more never triggers.
- R6: In trigger mode 2, the terminal count of channel `idx` marks the channel pending, so the two transfers run back to back.
- R7: When several channels are pending, the lowest index is served first. The engine performs at most one unit per two cycles, and write cycles are never adjacent.
- R8: The terminal count sets a sticky done flag, which only a `done_clr` pulse clears. `irq` is 1 exactly when some done flag is set with its mask bit set.
- R9: A trigger of any kind (software in every mode, or the selected one) is ignored while the channel is disabled and is not remembered.
- R10: Configuration writes use `cfg_sel` 0 = source, 1 = destination, 2 = count, 3 = control. The control word bits are: 0 enable, 1 source increment, 2 destination increment, 3 halfword, 4 interrupt mask, 6:5 trigger mode (0 software only, 1 peripheral, 2 chained), 10:7 trigger index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | Register selected (R10) |
| cfg_wdata | input | DW | Configuration write data |
| sw_req | input | NCH | Software request pulse per channel |
| periph_req | input | NPER | Peripheral request lines |
| done_clr | input | NCH | Clear pulse for each done flag |
| mem_req | output | 1 | Bus cycle valid |
| mem_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_half | output | 1 | Unit size, 1 = halfword |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the read |
| done | output | NCH | Sticky completion flags |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench builds the block with four channels, three peripheral lines and a 4-bit count. Channel 3 can then chain from channel 2, and a same-cycle software request on three channels shows the fixed ordering. The peripheral index 3 lies past the last line, which puts the out-of-range trigger case within reach. The short count keeps each terminal count a few units away, so every channel reaches it, disables itself and is then probed with late triggers.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int IDX_W    = 4;
  localparam int IDX_SPAN = 1 << IDX_W;

  typedef enum logic [1:0] {
    TRG_SW     = 2'd0,
    TRG_PERIPH = 2'd1,
    TRG_CHAIN  = 2'd2
  } trig_mode_e;

  typedef enum logic [1:0] {
    CFG_SRC  = 2'd0,
    CFG_DST  = 2'd1,
    CFG_CNT  = 2'd2,
    CFG_CTRL = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_WR   = 1'b1
  } eng_state_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    trig_mode_e       mode;
    logic             irq_en;
    logic             half;
    logic             dst_inc;
    logic             src_inc;
    logic             en;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N = 10
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pri
      assign gnt[i]      = req[i] & ~seen[i];
      assign seen[i + 1] = seen[i] | req[i];
    end
  endgenerate

  assign any = seen[N];
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int NCH  = 10,
  parameter int NPER = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            sw_req,
  input  logic [NPER-1:0] periph_req,
  input  logic [NCH-1:0]  tc_all,
  input  logic            rd_gnt,
  input  logic            wr_step,
  input  logic            done_clr,
  output logic [AW-1:0]   src_addr,
  output logic [AW-1:0]   dst_addr,
  output chan_ctrl_t      ctrl,
  output logic            req,
  output logic            done,
  output logic            tc
);
  logic [AW-1:0] src_q, src_n, dst_q, dst_n, step;
  logic [CW-1:0] cnt_q, cnt_n;
  chan_ctrl_t    ctrl_q, ctrl_n;
  logic          pend_q, pend_n, done_q, done_n;
  logic          sel_ev, hit;
  logic [IDX_SPAN-1:0] per_ext, tc_ext;

  assign per_ext = IDX_SPAN'(periph_req);
  assign tc_ext  = IDX_SPAN'(tc_all);
  assign step    = ctrl_q.half ? AW'(2) : AW'(1);
  assign tc      = wr_step && (cnt_q == CW'(1));

  always_comb begin
    case (ctrl_q.mode)
      TRG_PERIPH: sel_ev = (32'(ctrl_q.idx) < NPER) && per_ext[ctrl_q.idx];
      TRG_CHAIN:  sel_ev = (32'(ctrl_q.idx) < NCH) && tc_ext[ctrl_q.idx];
      default:    sel_ev = 1'b0;
    endcase
  end

  assign hit = ctrl_q.en && (sw_req || sel_ev);

  always_comb begin
    src_n  = src_q;
    dst_n  = dst_q;
    cnt_n  = cnt_q;
    ctrl_n = ctrl_q;
    pend_n = pend_q;
    done_n = done_q;
    if (wr_step) begin
      if (ctrl_q.src_inc) src_n = src_q + step;
      if (ctrl_q.dst_inc) dst_n = dst_q + step;
      cnt_n = cnt_q - CW'(1);
      if (tc) ctrl_n.en = 1'b0;
    end
    if (rd_gnt) pend_n = 1'b0;
    if (hit)    pend_n = 1'b1;
    if (tc)     pend_n = 1'b0;
    if (done_clr) done_n = 1'b0;
    if (tc)       done_n = 1'b1;
    if (cfg_we) begin
      case (cfg_sel)
        CFG_SRC: src_n = AW'(cfg_wdata);
        CFG_DST: dst_n = AW'(cfg_wdata);
        CFG_CNT: cnt_n = CW'(cfg_wdata);
        default: begin
          ctrl_n = chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
          if (!ctrl_n.en) pend_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      src_q  <= src_n;
      dst_q  <= dst_n;
      cnt_q  <= cnt_n;
      ctrl_q <= ctrl_n;
      pend_q <= pend_n;
      done_q <= done_n;
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign ctrl     = ctrl_q;
  assign req      = pend_q && ctrl_q.en;
  assign done     = done_q;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int NCH  = 10,
  parameter int NPER = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [1:0]      cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [NCH-1:0]  sw_req,
  input  logic [NPER-1:0] periph_req,
  input  logic [NCH-1:0]  done_clr,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_half,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [NCH-1:0]  done,
  output logic            irq
);
  eng_state_e     st_q, st_n;
  logic [CHW-1:0] cur_q, cur_n, gidx;
  logic [NCH-1:0] chan_req, gnt, rd_gnt, wr_step, tc_vec, irq_en;
  logic           any;
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  chan_ctrl_t     ctrl_a [NCH];

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      assign rd_gnt[i]  = (st_q == ENG_IDLE) && gnt[i];
      assign wr_step[i] = (st_q == ENG_WR) && (cur_q == CHW'(i));
      assign irq_en[i]  = ctrl_a[i].irq_en;
      dma_chan #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH), .NPER(NPER)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we && (cfg_ch == CHW'(i))),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .sw_req    (sw_req[i]),
        .periph_req(periph_req),
        .tc_all    (tc_vec),
        .rd_gnt    (rd_gnt[i]),
        .wr_step   (wr_step[i]),
        .done_clr  (done_clr[i]),
        .src_addr  (src_a[i]),
        .dst_addr  (dst_a[i]),
        .ctrl      (ctrl_a[i]),
        .req       (chan_req[i]),
        .done      (done[i]),
        .tc        (tc_vec[i])
      );
    end
  endgenerate

  dma_arb #(.N(NCH)) u_arb (
    .req(chan_req),
    .gnt(gnt),
    .any(any)
  );

  always_comb begin
    gidx = '0;
    for (int k = 0; k < NCH; k++) begin
      if (gnt[k]) gidx = CHW'(k);
    end
  end

  always_comb begin
    st_n  = st_q;
    cur_n = cur_q;
    if (st_q == ENG_IDLE) begin
      if (any) begin
        st_n  = ENG_WR;
        cur_n = gidx;
      end
    end else begin
      st_n = ENG_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cur_q <= '0;
    end else begin
      st_q  <= st_n;
      cur_q <= cur_n;
    end
  end

  assign mem_req   = (st_q == ENG_WR) || any;
  assign mem_we    = (st_q == ENG_WR);
  assign mem_addr  = (st_q == ENG_WR) ? dst_a[cur_q] : src_a[gidx];
  assign mem_half  = (st_q == ENG_WR) ? ctrl_a[cur_q].half : ctrl_a[gidx].half;
  assign mem_wdata = mem_rdata;
  assign irq       = |(done & irq_en);
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
  parameter int NCH = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_half,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] done_clr,
  input logic           irq
);
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_req && mem_we)); // R2

  AST_NO_ADJACENT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !(mem_req && mem_we)); // R7

  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_half == $past(mem_half))); // R3

  AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done != '0)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(done) & ~done & ~$past(done_clr)) == '0)); // R8
endmodule

bind dma_ctrl dma_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .mem_half(mem_half),
  .done    (done),
  .done_clr(done_clr),
  .irq     (irq)
);

// File: tb/dma_ctrl_test.sv
module dma_ctrl_test;
  localparam int NCH = 4;
  localparam int NPER = 3;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_ch;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic [3:0]  sw_req;
  logic [2:0]  periph_req;
  logic [3:0]  done_clr;
  logic        mem_req, mem_we, mem_half, irq;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_ctrl #(.AW(16), .DW(16), .CW(CW), .NCH(NCH), .NPER(NPER)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sw_req(sw_req), .periph_req(periph_req), .done_clr(done_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .irq(irq)
  );

  // bus slave memory
  logic [15:0] mem [256];
  function automatic logic [15:0] init_val(int a);
    return 16'((a * 16'h0107) ^ 16'h5a3c);
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_req && mem_we)  mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_src [4];
  logic [15:0] m_dst [4];
  int          m_cnt [4];
  logic [15:0] m_ctl [4];
  bit          m_pend [4];
  bit          m_done [4];
  bit          m_busy;
  int          m_cur;
  int          wr_seen;
  logic [15:0] wq [$];

  function automatic bit en_of(int c);   return m_ctl[c][0]; endfunction
  function automatic bit half_of(int c); return m_ctl[c][3]; endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0; m_ctl[c] = 0;
        m_pend[c] = 0; m_done[c] = 0;
      end
      m_busy = 0; m_cur = 0;
    end else begin
      int g;
      bit tcv [4];
      bit trig [4];
      bit e_req, e_we, e_half, e_irq;
      logic [15:0] e_addr;
      logic [3:0] e_done;
      g = -1;
      for (int c = 3; c >= 0; c--) if (!m_busy && en_of(c) && m_pend[c]) g = c;
      e_req = m_busy || (g >= 0);
      e_we = m_busy;
      e_addr = m_busy ? m_dst[m_cur] : (g >= 0 ? m_src[g] : mem_addr);
      e_half = m_busy ? half_of(m_cur) : (g >= 0 ? half_of(g) : mem_half);
      e_irq = 0;
      for (int c = 0; c < 4; c++) begin
        e_done[c] = m_done[c];
        if (m_done[c] && m_ctl[c][4]) e_irq = 1;
      end
      check(mem_req == e_req, "R2 mem_req", mem_req, e_req);
      check(mem_we == e_we, "R2 mem_we", mem_we, e_we);
      if (e_req) begin
        check(mem_addr == e_addr, "R3 mem_addr", mem_addr, e_addr);
        check(mem_half == e_half, "R3 mem_half", mem_half, e_half);
      end
      if (e_we) begin
        check(mem_wdata == mem_rdata, "R2 mem_wdata", mem_wdata, mem_rdata);
        wr_seen++;
        wq.push_back(mem_addr);
      end
      check(done == e_done, "R8 done", done, e_done);
      check(irq == e_irq, "R8 irq", irq, e_irq);
      // next state
      for (int c = 0; c < 4; c++) tcv[c] = m_busy && (m_cur == c) && (m_cnt[c] == 1);
      for (int c = 0; c < 4; c++) begin
        int ix;
        ix = int'(m_ctl[c][10:7]);
        trig[c] = sw_req[c];
        if (m_ctl[c][6:5] == 2'd1 && ix < NPER) trig[c] |= periph_req[ix];
        if (m_ctl[c][6:5] == 2'd2 && ix < NCH) trig[c] |= tcv[ix];
      end
      for (int c = 0; c < 4; c++) begin
        bit old_en;
        old_en = en_of(c);
        if (m_busy && m_cur == c) begin
          if (m_ctl[c][1]) m_src[c] += half_of(c) ? 16'd2 : 16'd1;
          if (m_ctl[c][2]) m_dst[c] += half_of(c) ? 16'd2 : 16'd1;
          m_cnt[c] = (m_cnt[c] + 15) % 16;
          if (tcv[c]) m_ctl[c][0] = 0;
        end
        if (g == c) m_pend[c] = 0;
        if (old_en && trig[c]) m_pend[c] = 1;
        if (tcv[c]) m_pend[c] = 0;
        if (done_clr[c]) m_done[c] = 0;
        if (tcv[c]) m_done[c] = 1;
        if (cfg_we && cfg_ch == c) begin
          case (cfg_sel)
            2'd0: m_src[c] = cfg_wdata;
            2'd1: m_dst[c] = cfg_wdata;
            2'd2: m_cnt[c] = cfg_wdata % 16;
            default: begin
              m_ctl[c] = {5'd0, cfg_wdata[10:0]};
              if (!cfg_wdata[0]) m_pend[c] = 0;
            end
          endcase
        end
      end
      if (m_busy) m_busy = 0;
      else if (g >= 0) begin m_busy = 1; m_cur = g; end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(int ch, int sel, logic [15:0] d);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    tick(1);
    cfg_we = 0;
  endtask

  function automatic logic [15:0] ctl(bit en, bit si, bit di, bit hw, bit im, int mode, int idx);
    return {5'd0, 4'(idx), 2'(mode), im, hw, di, si, en};
  endfunction

  task automatic setup(int ch, int s, int d, int n, logic [15:0] c);
    cfg(ch, 0, 16'(s)); cfg(ch, 1, 16'(d)); cfg(ch, 2, 16'(n)); cfg(ch, 3, c);
  endtask

  task automatic pulse_sw(logic [3:0] v);
    sw_req = v; tick(1); sw_req = 0;
  endtask

  task automatic pulse_per(logic [2:0] v);
    periph_req = v; tick(1); periph_req = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    for (int a = 0; a < 256; a++) mem[a] = init_val(a);
    mem_rdata = 0;
    rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_sel = 0; cfg_wdata = 0;
    sw_req = 0; periph_req = 0; done_clr = 0; wr_seen = 0;
    tick(3);
    rst_n = 1;
    @(negedge clk); #1;
    check(mem_req == 0, "R1 mem_req", mem_req, 0);
    check(done == 0, "R1 done", done, 0);
    check(irq == 0, "R1 irq", irq, 0);
    tick(1);

    // R2 R4: software transfers, byte, both pointers advance
    setup(0, 'h10, 'h40, 3, ctl(1, 1, 1, 0, 1, 0, 0));
    for (int k = 0; k < 3; k++) begin pulse_sw(4'b0001); tick(4); end
    for (int k = 0; k < 3; k++)
      check(mem['h40 + k] == init_val('h10 + k), "R2 copied unit", mem['h40 + k], init_val('h10 + k));
    check(done[0] == 1, "R4 terminal count done", done[0], 1);
    check(irq == 1, "R8 masked irq raised", irq, 1);
    check(mem['h43] == init_val('h43), "R4 no extra unit", mem['h43], init_val('h43));
    // R9: trigger after terminal count is ignored
    w0 = wr_seen;
    pulse_sw(4'b0001); tick(6);
    check(wr_seen == w0, "R9 disabled channel idle", wr_seen, w0);
    done_clr = 4'b0001; tick(1); done_clr = 0;
    @(negedge clk); #1;
    check(done[0] == 0 && irq == 0, "R8 done_clr clears", {done[0], irq}, 0);
    tick(1);

    // R3 R5: peripheral trigger, halfword, fixed source
    setup(1, 'h20, 'h60, 2, ctl(1, 0, 1, 1, 0, 1, 2));
    w0 = wr_seen;
    pulse_per(3'b010); tick(5);
    check(wr_seen == w0, "R5 other line ignored", wr_seen, w0);
    pulse_per(3'b100); tick(4);
    pulse_per(3'b100); tick(4);
    check(mem['h60] == init_val('h20), "R3 first halfword", mem['h60], init_val('h20));
    check(mem['h62] == init_val('h20), "R3 fixed source step 2", mem['h62], init_val('h20));
    check(mem['h61] == init_val('h61), "R3 skipped byte", mem['h61], init_val('h61));
    check(done[1] == 1 && irq == 0, "R8 unmasked done no irq", {done[1], irq}, 2);
    // R5: index past last line never triggers
    setup(1, 'h24, 'h68, 1, ctl(1, 1, 1, 0, 0, 1, 3));
    w0 = wr_seen;
    pulse_per(3'b111); tick(5);
    check(wr_seen == w0, "R5 out-of-range index", wr_seen, w0);
    cfg(1, 3, ctl(0, 0, 0, 0, 0, 0, 0));

    // R6: chain channel 3 on channel 2 terminal count
    setup(2, 'h80, 'h90, 1, ctl(1, 1, 1, 0, 0, 0, 0));
    setup(3, 'hA0, 'hB0, 1, ctl(1, 1, 1, 0, 1, 2, 2));
    pulse_sw(4'b0100); tick(8);
    check(mem['h90] == init_val('h80), "R6 first link", mem['h90], init_val('h80));
    check(mem['hB0] == init_val('hA0), "R6 chained link", mem['hB0], init_val('hA0));
    check(done[3] == 1 && irq == 1, "R6 chained done", {done[3], irq}, 3);
    done_clr = 4'b1110; tick(1); done_clr = 0;
    w0 = wr_seen;
    pulse_sw(4'b0100); tick(6);
    check(wr_seen == w0, "R9 finished channel ignores sw", wr_seen, w0);

    // R7: same-cycle requests served lowest index first
    setup(0, 'h30, 'h70, 1, ctl(1, 1, 1, 0, 0, 0, 0));
    setup(1, 'h31, 'h71, 1, ctl(1, 1, 1, 0, 0, 1, 0));
    setup(3, 'h33, 'h73, 1, ctl(1, 1, 1, 0, 0, 0, 0));
    wq.delete();
    pulse_sw(4'b1011); tick(10);
    check(wq.size() == 3, "R7 three units", wq.size(), 3);
    if (wq.size() == 3) begin
      check(wq[0] == 16'h70, "R7 order first", wq[0], 'h70);
      check(wq[1] == 16'h71, "R7 order second", wq[1], 'h71);
      check(wq[2] == 16'h73, "R7 order third", wq[2], 'h73);
    end
    check(mem['h73] == init_val('h33), "R7 last unit data", mem['h73], init_val('h33));

    // R10: disabling via control write drops a pending request
    setup(2, 'h50, 'hC0, 2, ctl(1, 1, 1, 0, 0, 1, 0));
    cfg(2, 3, ctl(0, 1, 1, 0, 0, 1, 0));
    w0 = wr_seen;
    pulse_per(3'b001); tick(5);
    check(wr_seen == w0, "R10 R9 disabled via control", wr_seen, w0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule